// File: doc/BRIEF.md
# Logical Device Configuration Bank with Range-Check Responder

This block holds the configuration registers of one logical device on a plug-and-play expansion card and answers host I/O reads during a conflict probe. The card controller reaches the registers through an 8-bit configuration index with a write strobe and write data. The read data follows the index combinationally. The bank holds an activate bit, a range-check control register, up to eight 16-bit I/O base addresses, two interrupt entries and two DMA channel selectors. Every reserved bit reads back as zero.

While the range check is enabled and the device is not active, a host I/O read whose address falls in the window of any nonzero base returns a fixed test pattern. Firmware uses this to see whether another agent already decodes the same addresses. The pattern is 0x55 or 0xAA, chosen by a control bit. Setting the activate bit drops the range-check enable, so an active device never drives test patterns. A logical-device reset pulse from the card controller returns the whole bank to its power-up values.

Top module: `ldev_cfg_resp`

## Requirements
- R1: After rst_n is released, every configuration index reads 0x00, except indices 0x74 and 0x75, which read 0x04. io_hit is 0 and io_rdata is 0x00.
- R2: Index 0x30 holds the activate bit in bit 0. A write stores wdata[0], and bits [7:1] always read as 0.
- R3: Index 0x31 holds the range-check enable in bit 1 and the pattern select in bit 0. A write stores wdata[1:0], and bits [7:2] always read as 0.
- R4: A write of 1 to bit 0 of index 0x30 also clears the range-check enable (bit 1 of 0x31) in the same cycle. The pattern select bit keeps its value.
- R5: Base n (n from 0 to NUM_BASE-1) is at index 0x60+2n (bits [15:8]) and index 0x61+2n (bits [7:0]). All eight bits read back as written.
- R6: Interrupt entry e (e = 0 or 1) has its level at index 0x70+2e and its control at index 0x71+2e. The level keeps wdata[3:0] and reads [7:4] as 0. The control keeps wdata[1:0] (bit 1 polarity, bit 0 trigger type) and reads [7:2] as 0.
- R7: DMA selector d (d = 0 or 1) is at index 0x74+d. It keeps wdata[2:0] and reads [7:3] as 0. Its power-up value is 4, meaning no channel.
- R8: When io_rd is high and the enable is set, the device is inactive, and io_addr lies in [base, base+RANGE_LEN-1] for any nonzero base, then on the next clock io_hit is 1. On that clock io_rdata is 0x55 if the pattern bit is 1 and 0xAA if it is 0.
- R9: In every other case io_hit is 0 and io_rdata is 0x00 on the next clock. This covers a zero base, an address outside every window, a cleared enable, an active device even with the enable set, and no io_rd.
- R10: A one-cycle ldev_rst pulse returns every register to its R1 value on the following clock.
- R11: Writes to any index not named in R2 to R7 change no register, and those indices read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ldev_rst | input | 1 | Synchronous logical-device reset pulse |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_idx | input | 8 | Configuration register index |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for cfg_idx |
| io_rd | input | 1 | Host I/O read strobe |
| io_addr | input | 16 | Host I/O address |
| io_hit | output | 1 | Range-check response valid, one clock after io_rd |
| io_rdata | output | 8 | Range-check test pattern, 0x00 when not responding |

## Verification
The assertions assume that the card controller issues at most one configuration write per cycle. They also assume that ldev_rst, when asserted, takes priority over a write in the same cycle. The io_rd strobe is assumed to be sampled only on the clock edge, with io_addr stable alongside it.

The bench changes inputs only on the falling edge, keeps each write and each I/O read to a single cycle, and never overlaps a write with ldev_rst. Probe addresses straddle each window by two addresses on both sides. One window sits at the very top of the 16-bit space, which exercises the upper-bound comparison without any wrap.

// File: rtl/ldev_pkg.sv
package ldev_pkg;
   localparam int unsigned IDX_W   = 8;
   localparam int unsigned DATA_W  = 8;
   localparam int unsigned IOA_W   = 16;

   localparam logic [IDX_W-1:0] IX_ACT   = 8'h30;
   localparam logic [IDX_W-1:0] IX_RCHK  = 8'h31;
   localparam logic [3:0]       IX_BASE_HI_NIB = 4'h6;
   localparam logic [5:0]       IX_IRQ_HI6 = 6'b011100;
   localparam logic [IDX_W-1:0] IX_DMA0  = 8'h74;

   localparam logic [DATA_W-1:0] PAT_ONE  = 8'h55;
   localparam logic [DATA_W-1:0] PAT_ZERO = 8'hAA;
   localparam logic [2:0]        DMA_NONE = 3'd4;

   typedef struct packed {
      logic [3:0] level;
      logic [1:0] ctl;
   } irq_ent_t;
endpackage

// File: rtl/ldev_regbank.sv
module ldev_regbank
   import ldev_pkg::*;
#(
   parameter int unsigned NUM_BASE = 8,
   parameter int unsigned NUM_IRQ  = 2,
   parameter int unsigned NUM_DMA  = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ldev_rst,
   input  logic                       cfg_wr,
   input  logic [IDX_W-1:0]           cfg_idx,
   input  logic [DATA_W-1:0]          cfg_wdata,
   output logic [DATA_W-1:0]          cfg_rdata,
   output logic                       act_o,
   output logic                       rc_en_o,
   output logic                       rc_pat_o,
   output logic [NUM_BASE-1:0][IOA_W-1:0] base_o
);
   generate
      if (NUM_BASE < 1 || NUM_BASE > 8) begin : g_bad_base
         $error("NUM_BASE must be 1..8");
      end
      if (NUM_IRQ < 1 || NUM_IRQ > 2) begin : g_bad_irq
         $error("NUM_IRQ must be 1..2");
      end
      if (NUM_DMA < 1 || NUM_DMA > 2) begin : g_bad_dma
         $error("NUM_DMA must be 1..2");
      end
   endgenerate

   logic             act_q, rc_en_q, rc_pat_q;
   logic [IOA_W-1:0] base_q [NUM_BASE];
   irq_ent_t         irq_q  [NUM_IRQ];
   logic [2:0]       dma_q  [NUM_DMA];

   // control registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q    <= 1'b0;
         rc_en_q  <= 1'b0;
         rc_pat_q <= 1'b0;
      end else if (ldev_rst) begin
         act_q    <= 1'b0;
         rc_en_q  <= 1'b0;
         rc_pat_q <= 1'b0;
      end else if (cfg_wr) begin
         if (cfg_idx == IX_ACT) begin
            act_q <= cfg_wdata[0];
            if (cfg_wdata[0]) rc_en_q <= 1'b0;
         end else if (cfg_idx == IX_RCHK) begin
            rc_en_q  <= cfg_wdata[1];
            rc_pat_q <= cfg_wdata[0];
         end
      end
   end

   // base address registers, high byte at even index
   for (genvar g = 0; g < NUM_BASE; g++) begin : g_base
      logic sel;
      assign sel = cfg_wr && (cfg_idx[7:4] == IX_BASE_HI_NIB) && (cfg_idx[3:1] == 3'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        base_q[g] <= '0;
         else if (ldev_rst) base_q[g] <= '0;
         else if (sel) begin
            if (cfg_idx[0]) base_q[g][7:0]  <= cfg_wdata;
            else            base_q[g][15:8] <= cfg_wdata;
         end
      end
      assign base_o[g] = base_q[g];
   end

   // interrupt entries: level then control
   for (genvar g = 0; g < NUM_IRQ; g++) begin : g_irq
      logic sel;
      assign sel = cfg_wr && (cfg_idx[7:2] == IX_IRQ_HI6) && (cfg_idx[1] == 1'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        irq_q[g] <= '0;
         else if (ldev_rst) irq_q[g] <= '0;
         else if (sel) begin
            if (cfg_idx[0]) irq_q[g].ctl   <= cfg_wdata[1:0];
            else            irq_q[g].level <= cfg_wdata[3:0];
         end
      end
   end

   // DMA channel selectors
   for (genvar g = 0; g < NUM_DMA; g++) begin : g_dma
      logic sel;
      assign sel = cfg_wr && (cfg_idx == IX_DMA0 + IDX_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        dma_q[g] <= DMA_NONE;
         else if (ldev_rst) dma_q[g] <= DMA_NONE;
         else if (sel)      dma_q[g] <= cfg_wdata[2:0];
      end
   end

   // read multiplexer with reserved bits forced to zero
   always_comb begin
      cfg_rdata = '0;
      if (cfg_idx == IX_ACT) begin
         cfg_rdata = {7'b0, act_q};
      end else if (cfg_idx == IX_RCHK) begin
         cfg_rdata = {6'b0, rc_en_q, rc_pat_q};
      end else if (cfg_idx[7:4] == IX_BASE_HI_NIB) begin
         for (int i = 0; i < NUM_BASE; i++)
            if (cfg_idx[3:1] == 3'(i))
               cfg_rdata = cfg_idx[0] ? base_q[i][7:0] : base_q[i][15:8];
      end else if (cfg_idx[7:2] == IX_IRQ_HI6) begin
         for (int i = 0; i < NUM_IRQ; i++)
            if (cfg_idx[1] == 1'(i))
               cfg_rdata = cfg_idx[0] ? {6'b0, irq_q[i].ctl} : {4'b0, irq_q[i].level};
      end else begin
         for (int i = 0; i < NUM_DMA; i++)
            if (cfg_idx == IX_DMA0 + IDX_W'(i))
               cfg_rdata = {5'b0, dma_q[i]};
      end
   end

   assign act_o    = act_q;
   assign rc_en_o  = rc_en_q;
   assign rc_pat_o = rc_pat_q;
endmodule

// File: rtl/ldev_range_match.sv
module ldev_range_match
   import ldev_pkg::*;
#(
   parameter int unsigned NUM_BASE  = 8,
   parameter int unsigned RANGE_LEN = 8
) (
   input  logic [NUM_BASE-1:0][IOA_W-1:0] base_i,
   input  logic [IOA_W-1:0]               addr_i,
   output logic                           hit_o
);
   localparam int unsigned CMP_W = IOA_W + 1;

   generate
      if (RANGE_LEN < 1 || RANGE_LEN > (1 << IOA_W)) begin : g_bad_len
         $error("RANGE_LEN out of range");
      end
   endgenerate

   logic [NUM_BASE-1:0] hit_v;

   // one window comparator per base, widened by a bit so the top window cannot wrap
   for (genvar g = 0; g < NUM_BASE; g++) begin : g_win
      logic [CMP_W-1:0] lo, hi, a;
      assign lo = {1'b0, base_i[g]};
      assign hi = lo + CMP_W'(RANGE_LEN);
      assign a  = {1'b0, addr_i};
      assign hit_v[g] = (base_i[g] != '0) && (a >= lo) && (a < hi);
   end

   assign hit_o = |hit_v;
endmodule

// File: rtl/ldev_cfg_resp.sv
module ldev_cfg_resp
   import ldev_pkg::*;
#(
   parameter int unsigned NUM_BASE  = 8,
   parameter int unsigned NUM_IRQ   = 2,
   parameter int unsigned NUM_DMA   = 2,
   parameter int unsigned RANGE_LEN = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ldev_rst,
   input  logic        cfg_wr,
   input  logic [7:0]  cfg_idx,
   input  logic [7:0]  cfg_wdata,
   output logic [7:0]  cfg_rdata,
   input  logic        io_rd,
   input  logic [15:0] io_addr,
   output logic        io_hit,
   output logic [7:0]  io_rdata
);
   logic act, rc_en, rc_pat, win_hit, respond;
   logic [NUM_BASE-1:0][IOA_W-1:0] base;

   ldev_regbank #(
      .NUM_BASE (NUM_BASE),
      .NUM_IRQ  (NUM_IRQ),
      .NUM_DMA  (NUM_DMA)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .ldev_rst  (ldev_rst),
      .cfg_wr    (cfg_wr),
      .cfg_idx   (cfg_idx),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .act_o     (act),
      .rc_en_o   (rc_en),
      .rc_pat_o  (rc_pat),
      .base_o    (base)
   );

   ldev_range_match #(
      .NUM_BASE  (NUM_BASE),
      .RANGE_LEN (RANGE_LEN)
   ) u_match (
      .base_i (base),
      .addr_i (io_addr),
      .hit_o  (win_hit)
   );

   assign respond = io_rd && rc_en && !act && win_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         io_hit   <= 1'b0;
         io_rdata <= '0;
      end else begin
         io_hit   <= respond;
         io_rdata <= respond ? (rc_pat ? PAT_ONE : PAT_ZERO) : '0;
      end
   end
endmodule

// File: rtl/ldev_cfg_resp_chk.sv
module ldev_cfg_resp_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        ldev_rst,
   input logic        cfg_wr,
   input logic [7:0]  cfg_idx,
   input logic [7:0]  cfg_wdata,
   input logic [7:0]  cfg_rdata,
   input logic        io_rd,
   input logic        io_hit,
   input logic [7:0]  io_rdata,
   input logic        act,
   input logic        rc_en
);
   p_act_rsvd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_idx == 8'h30) |-> (cfg_rdata[7:1] == 7'b0));

   p_rchk_rsvd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_idx == 8'h31) |-> (cfg_rdata[7:2] == 6'b0));

   p_act_clears_rc_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && !ldev_rst && cfg_idx == 8'h30 && cfg_wdata[0]) |=> !rc_en);

   p_dma_rsvd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_idx == 8'h74 || cfg_idx == 8'h75) |-> (cfg_rdata[7:3] == 5'b0));

   p_pattern_r8: assert property (@(posedge clk) disable iff (!rst_n)
      io_hit |-> (io_rdata == 8'h55 || io_rdata == 8'hAA));

   p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !io_hit |-> (io_rdata == 8'h00));

   p_quiet_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
      act |=> !io_hit);

   p_quiet_no_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !io_rd |=> !io_hit);

   p_ldev_rst_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ldev_rst |=> (!act && !rc_en));
endmodule

bind ldev_cfg_resp ldev_cfg_resp_chk u_chk (.*);

// File: tb/ldev_cfg_resp_tb.sv
module ldev_cfg_resp_tb;
   localparam int NB  = 8;
   localparam int LEN = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ldev_rst = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [7:0]  cfg_idx = '0;
   logic [7:0]  cfg_wdata = '0;
   logic [7:0]  cfg_rdata;
   logic        io_rd = 1'b0;
   logic [15:0] io_addr = '0;
   logic        io_hit;
   logic [7:0]  io_rdata;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // model of the register bank, built from the requirements
   bit         m_act, m_rce, m_pat;
   logic [15:0] m_base [NB];
   logic [3:0]  m_lvl [2];
   logic [1:0]  m_ctl [2];
   logic [2:0]  m_dma [2];

   always #4 clk = ~clk;

   ldev_cfg_resp #(.NUM_BASE(NB), .RANGE_LEN(LEN)) u_dut (
      .clk(clk), .rst_n(rst_n), .ldev_rst(ldev_rst),
      .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .io_rd(io_rd), .io_addr(io_addr), .io_hit(io_hit), .io_rdata(io_rdata)
   );

   task automatic m_defaults();
      m_act = 0; m_rce = 0; m_pat = 0;
      for (int i = 0; i < NB; i++) m_base[i] = '0;
      for (int i = 0; i < 2; i++) begin m_lvl[i] = '0; m_ctl[i] = '0; m_dma[i] = 3'd4; end
   endtask

   function automatic logic [7:0] exp_rd(input int ix);
      if (ix == 'h30) return {7'b0, m_act};
      if (ix == 'h31) return {6'b0, m_rce, m_pat};
      if (ix >= 'h60 && ix < 'h60 + 2*NB)
         return (ix % 2) ? m_base[(ix-'h60)/2][7:0] : m_base[(ix-'h60)/2][15:8];
      if (ix >= 'h70 && ix <= 'h73)
         return (ix % 2) ? {6'b0, m_ctl[(ix-'h70)/2]} : {4'b0, m_lvl[(ix-'h70)/2]};
      if (ix == 'h74 || ix == 'h75) return {5'b0, m_dma[ix-'h74]};
      return 8'h00;
   endfunction

   function automatic string tag_of(input int ix);
      if (ix == 'h30) return "R2";
      if (ix == 'h31) return "R3";
      if (ix >= 'h60 && ix < 'h60 + 2*NB) return "R5";
      if (ix >= 'h70 && ix <= 'h73) return "R6";
      if (ix == 'h74 || ix == 'h75) return "R7";
      return "R11";
   endfunction

   function automatic bit exp_hit(input int a);
      if (!m_rce || m_act) return 0;
      for (int i = 0; i < NB; i++)
         if (m_base[i] != 0 && a >= int'(m_base[i]) && a < int'(m_base[i]) + LEN) return 1;
      return 0;
   endfunction

   task automatic check8(input string tag, input string what, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
      end
   endtask

   task automatic wr(input int ix, input logic [7:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_idx = 8'(ix); cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
      if (ix == 'h30) begin m_act = d[0]; if (d[0]) m_rce = 0; end
      else if (ix == 'h31) begin m_rce = d[1]; m_pat = d[0]; end
      else if (ix >= 'h60 && ix < 'h60 + 2*NB) begin
         if (ix % 2) m_base[(ix-'h60)/2][7:0] = d; else m_base[(ix-'h60)/2][15:8] = d;
      end
      else if (ix >= 'h70 && ix <= 'h73) begin
         if (ix % 2) m_ctl[(ix-'h70)/2] = d[1:0]; else m_lvl[(ix-'h70)/2] = d[3:0];
      end
      else if (ix == 'h74 || ix == 'h75) m_dma[ix-'h74] = d[2:0];
   endtask

   task automatic rd_chk(input int ix, input string tag);
      @(negedge clk);
      cfg_idx = 8'(ix);
      #1;
      check8(tag, $sformatf("read idx %02h", ix), cfg_rdata, exp_rd(ix));
   endtask

   task automatic sweep_all(input string tag);
      for (int ix = 0; ix < 256; ix++) rd_chk(ix, (tag == "") ? tag_of(ix) : tag);
   endtask

   task automatic io_chk(input int a);
      bit eh;
      eh = exp_hit(a);
      @(negedge clk);
      io_rd = 1'b1; io_addr = 16'(a);
      @(negedge clk);
      io_rd = 1'b0;
      check8(eh ? "R8" : "R9", $sformatf("io hit @%04h", 16'(a)), {7'b0, io_hit}, {7'b0, eh});
      check8(eh ? "R8" : "R9", $sformatf("io data @%04h", 16'(a)), io_rdata,
             eh ? (m_pat ? 8'h55 : 8'hAA) : 8'h00);
   endtask

   task automatic probe_windows();
      for (int i = 0; i < NB; i++)
         if (m_base[i] != 0)
            for (int a = int'(m_base[i]) - 2; a <= int'(m_base[i]) + LEN + 1; a++)
               io_chk(a & 'hFFFF);
      for (int a = 0; a < 4; a++) io_chk(a);   // base of zero must not decode
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      m_defaults();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset values everywhere
      check8("R1", "io_hit after reset", {7'b0, io_hit}, 8'h00);
      check8("R1", "io_rdata after reset", io_rdata, 8'h00);
      sweep_all("R1");

      // all-ones write sweep exercises masking on every index (R2 R3 R5 R6 R7 R11)
      for (int ix = 0; ix < 256; ix++) wr(ix, 8'hFF);
      sweep_all("");

      // R10: logical-device reset
      @(negedge clk); ldev_rst = 1'b1;
      @(negedge clk); ldev_rst = 1'b0;
      m_defaults();
      sweep_all("R10");

      // arithmetic pattern write sweep
      for (int ix = 0; ix < 256; ix++) wr(ix, 8'((ix * 37 + 5) & 'hFF));
      sweep_all("");
      wr('h30, 8'h00);

      // R4: activate clears enable, keeps pattern select
      wr('h31, 8'h03);
      wr('h30, 8'h01);
      rd_chk('h31, "R4");
      check8("R4", "enable model cleared", {7'b0, m_rce}, 8'h00);
      wr('h30, 8'h00);

      // range-check sweeps
      for (int i = 0; i < NB; i++) begin wr('h60 + 2*i, 8'h00); wr('h61 + 2*i, 8'h00); end
      wr('h60, 8'h02); wr('h61, 8'h00);   // base0 = 0x0200
      wr('h62, 8'h03); wr('h63, 8'hF8);   // base1 = 0x03F8
      wr('h66, 8'hFF); wr('h67, 8'hFC);   // base3 = 0xFFFC, top of space
      wr('h6E, 8'h12); wr('h6F, 8'h34);   // base7 = 0x1234
      wr('h31, 8'h03);                    // R8 pattern 0x55
      probe_windows();
      wr('h31, 8'h02);                    // R8 pattern 0xAA
      probe_windows();
      wr('h31, 8'h01);                    // R9 enable clear
      probe_windows();
      wr('h31, 8'h02);
      wr('h30, 8'h01);                    // R4 active device drops enable
      probe_windows();
      wr('h31, 8'h03);                    // R9 enable set while active: stored, silent
      rd_chk('h31, "R9");
      for (int a = 'h200; a < 'h200 + LEN; a++) begin
         @(negedge clk); io_rd = 1'b1; io_addr = 16'(a);
         @(negedge clk); io_rd = 1'b0;
         check8("R9", "active device silent", {7'b0, io_hit}, 8'h00);
      end
      wr('h30, 8'h00);                    // inactive again: responds
      probe_windows();

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule